// File: doc/BRIEF.md
# Banked UART Register File

This block is the host-side register decode of a 16550-style serial controller. A host drives a 3-bit register offset with read and write strobes and an 8-bit write bus. The block holds the line, modem, interrupt-enable and FIFO configuration. It presents that configuration as plain control pins to the shifters, the FIFOs and the baud generator, which are outside this block. It also returns read data taken from its own registers or from status inputs that those neighbours supply.

Offsets 0 and 1 are banked. While the divisor-latch bit (line control bit 7) is clear, offset 0 is the data port and offset 1 is the interrupt-enable register. While that bit is set, offsets 0 and 1 give access to the low and high bytes of the 16-bit baud divisor. Offset 2 is split by direction: reads return the interrupt identification byte from the interrupt logic, and writes load the FIFO configuration.

The data port has no back-pressure. A data write becomes a one-cycle push strobe to the transmit path, and a data read becomes a one-cycle pop strobe to the receive path. The host is responsible for polling status before it uses them. Every registered output changes on the clock edge that follows the strobe. Read data is combinational from the current offset.

Top module: `uart_regbank`

## Requirements
- R1: After reset every control output is 0: word length code 0 (5 bits), FIFOs disabled, all interrupt enables off, divisor 0, all modem outputs low, and no strobe active.
- R2: A write to offset 0 while line control bit 7 is 0 places the write byte on tx_byte and raises tx_push for exactly one cycle, both in the cycle after the write. It does not change the divisor.
- R3: A read of offset 0 while line control bit 7 is 0 returns rx_head and raises rx_pop for one cycle, in the cycle after the read. While bit 7 is 1, a read of offset 0 gives no pop.
- R4: While line control bit 7 is 1, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. baud_div shows the 16-bit value, and these accesses produce neither push nor pop.
- R5: While line control bit 7 is 0, a write to offset 1 stores bits 3:0 as int_en. A read of offset 1 returns them with bits 7:4 as zero.
- R6: A read of offset 2 returns irq_id. A write to offset 2 sets fifo_en from bit 0, ready_mode from bit 3 and rx_trigger from bits 7:6.
- R7: Write bits 1 and 2 at offset 2 give one-cycle rx_fifo_clr and tx_fifo_clr pulses in the cycle after the write. They are not held afterwards.
- R8: Offset 3 is the line control register, and it reads back whole. Its fields are: bits 1:0 word length (codes 0 to 3 select 5 to 8 bits), bit 2 two stop bits, bit 3 parity enable, bit 4 even parity, bit 5 stick parity, bit 6 break, bit 7 divisor latch.
- R9: Offset 4 is the modem control register. Bits 0 to 4 drive dtr, rts, out1, out2 and loopback, and a read returns those 5 bits with bits 7:5 as zero.
- R10: Reads of offsets 5 and 6 return line_stat and modem_stat.
- R11: A read of offset 7 returns 0. Writes to offsets 5, 6 and 7 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 3 | Register offset |
| reg_rd | input | 1 | Read strobe, one access per cycle high |
| reg_wr | input | 1 | Write strobe, one access per cycle high |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current offset |
| rx_head | input | 8 | Oldest received byte from the receive path |
| irq_id | input | 8 | Interrupt identification byte from the interrupt logic |
| line_stat | input | 8 | Line status byte |
| modem_stat | input | 8 | Modem status byte |
| tx_byte | output | 8 | Last byte written to the data port |
| tx_push | output | 1 | One-cycle transmit push strobe |
| rx_pop | output | 1 | One-cycle receive pop strobe |
| int_en | output | 4 | Interrupt enable bits |
| word_len | output | 2 | Word length code |
| two_stop | output | 1 | Two stop bits |
| parity_en | output | 1 | Parity enable |
| parity_even | output | 1 | Even parity select |
| parity_stick | output | 1 | Stick parity select |
| break_ctl | output | 1 | Force break on the line |
| baud_div | output | 16 | Baud divisor |
| dtr | output | 1 | Terminal ready output |
| rts | output | 1 | Request to send output |
| out1 | output | 1 | General output 1 |
| out2 | output | 1 | General output 2 |
| loopback | output | 1 | Loopback mode |
| fifo_en | output | 1 | FIFO enable |
| rx_fifo_clr | output | 1 | One-cycle receive FIFO clear |
| tx_fifo_clr | output | 1 | One-cycle transmit FIFO clear |
| ready_mode | output | 1 | Ready-pin mode select |
| rx_trigger | output | 2 | Receive trigger level code |

## Verification
The bench builds the block with its default parameters: 8-bit data, a 4-bit interrupt enable, 5 modem bits and a divisor of two bytes. With these values every offset and both banks are reachable through the 3-bit address. Random traffic toggles the divisor-latch bit in between accesses to offsets 0 and 1, so bank switching happens under strobes issued back to back. A behavioural model tracks each output every cycle, so a stray or held strobe shows up at once.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DATA  = 3'd0,
    OFS_IEN   = 3'd1,
    OFS_IDFC  = 3'd2,
    OFS_LINE  = 3'd3,
    OFS_MODEM = 3'd4,
    OFS_LSTAT = 3'd5,
    OFS_MSTAT = 3'd6,
    OFS_SPARE = 3'd7
  } ofs_e;

  typedef struct packed {
    logic       latch;
    logic       brk;
    logic       stick;
    logic       even;
    logic       par_en;
    logic       two_stop;
    logic [1:0] wlen;
  } line_cfg_t;

  typedef struct packed {
    logic [1:0] trig;
    logic       rdy_mode;
    logic       enable;
  } fifo_cfg_t;

  typedef struct packed {
    logic we_data;
    logic re_data;
    logic we_ien;
    logic we_fifo;
    logic we_line;
    logic we_modem;
  } sel_t;
endpackage

// File: rtl/uart_regbank_decode.sv
module uart_regbank_decode
  import uart_regbank_pkg::*;
#(
  parameter int DIV_BYTES = 2
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rd,
  input  logic               wr,
  input  logic               latch,
  output sel_t               sel,
  output logic [DIV_BYTES-1:0] we_div
);
  always_comb begin
    sel          = '0;
    sel.we_data  = wr && !latch && (addr == OFS_DATA);
    sel.re_data  = rd && !latch && (addr == OFS_DATA);
    sel.we_ien   = wr && !latch && (addr == OFS_IEN);
    sel.we_fifo  = wr && (addr == OFS_IDFC);
    sel.we_line  = wr && (addr == OFS_LINE);
    sel.we_modem = wr && (addr == OFS_MODEM);
  end

  for (genvar b = 0; b < DIV_BYTES; b++) begin : g_div_sel
    assign we_div[b] = wr && latch && (addr == ADDR_W'(b));
  end
endmodule

// File: rtl/uart_regbank_regs.sv
module uart_regbank_regs
  import uart_regbank_pkg::*;
#(
  parameter int DW        = 8,
  parameter int IEN_W     = 4,
  parameter int MDM_W     = 5,
  parameter int DIV_BYTES = 2,
  localparam int DIV_W    = DW * DIV_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  sel_t                 sel,
  input  logic [DIV_BYTES-1:0] we_div,
  input  logic [DW-1:0]        wdata,
  output line_cfg_t            line_q,
  output fifo_cfg_t            fifo_q,
  output logic [IEN_W-1:0]     ien_q,
  output logic [MDM_W-1:0]     mdm_q,
  output logic [DIV_W-1:0]     div_q,
  output logic [DW-1:0]        thr_q,
  output logic                 push_q,
  output logic                 pop_q,
  output logic                 rxclr_q,
  output logic                 txclr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      fifo_q <= '0;
      ien_q  <= '0;
      mdm_q  <= '0;
      thr_q  <= '0;
    end else begin
      if (sel.we_line)  line_q <= line_cfg_t'(wdata[7:0]);
      if (sel.we_ien)   ien_q  <= wdata[IEN_W-1:0];
      if (sel.we_modem) mdm_q  <= wdata[MDM_W-1:0];
      if (sel.we_data)  thr_q  <= wdata;
      if (sel.we_fifo) begin
        fifo_q.enable   <= wdata[0];
        fifo_q.rdy_mode <= wdata[3];
        fifo_q.trig     <= wdata[7:6];
      end
    end
  end

  // Strobes: high for the single cycle after the access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_q  <= 1'b0;
      pop_q   <= 1'b0;
      rxclr_q <= 1'b0;
      txclr_q <= 1'b0;
    end else begin
      push_q  <= sel.we_data;
      pop_q   <= sel.re_data;
      rxclr_q <= sel.we_fifo && wdata[1];
      txclr_q <= sel.we_fifo && wdata[2];
    end
  end

  for (genvar b = 0; b < DIV_BYTES; b++) begin : g_div_byte
    logic [DW-1:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        byte_q <= '0;
      else if (we_div[b]) byte_q <= wdata;
    end
    assign div_q[b*DW +: DW] = byte_q;
  end
endmodule

// File: rtl/uart_regbank_rdmux.sv
module uart_regbank_rdmux
  import uart_regbank_pkg::*;
#(
  parameter int DW        = 8,
  parameter int IEN_W     = 4,
  parameter int MDM_W     = 5,
  parameter int DIV_BYTES = 2,
  localparam int DIV_W    = DW * DIV_BYTES
) (
  input  logic [ADDR_W-1:0] addr,
  input  line_cfg_t         line_q,
  input  logic [IEN_W-1:0]  ien_q,
  input  logic [MDM_W-1:0]  mdm_q,
  input  logic [DIV_W-1:0]  div_q,
  input  logic [DW-1:0]     rx_head,
  input  logic [DW-1:0]     irq_id,
  input  logic [DW-1:0]     line_stat,
  input  logic [DW-1:0]     modem_stat,
  output logic [DW-1:0]     rdata
);
  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_DATA:  rdata = line_q.latch ? div_q[0 +: DW] : rx_head;
      OFS_IEN:   rdata = line_q.latch ? div_q[DW +: DW] : DW'(ien_q);
      OFS_IDFC:  rdata = irq_id;
      OFS_LINE:  rdata = DW'(line_q);
      OFS_MODEM: rdata = DW'(mdm_q);
      OFS_LSTAT: rdata = line_stat;
      OFS_MSTAT: rdata = modem_stat;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int DW        = 8,
  parameter int IEN_W     = 4,
  parameter int MDM_W     = 5,
  parameter int DIV_BYTES = 2,
  localparam int DIV_W    = DW * DIV_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [DW-1:0]     rx_head,
  input  logic [DW-1:0]     irq_id,
  input  logic [DW-1:0]     line_stat,
  input  logic [DW-1:0]     modem_stat,
  output logic [DW-1:0]     tx_byte,
  output logic              tx_push,
  output logic              rx_pop,
  output logic [IEN_W-1:0]  int_en,
  output logic [1:0]        word_len,
  output logic              two_stop,
  output logic              parity_en,
  output logic              parity_even,
  output logic              parity_stick,
  output logic              break_ctl,
  output logic [DIV_W-1:0]  baud_div,
  output logic              dtr,
  output logic              rts,
  output logic              out1,
  output logic              out2,
  output logic              loopback,
  output logic              fifo_en,
  output logic              rx_fifo_clr,
  output logic              tx_fifo_clr,
  output logic              ready_mode,
  output logic [1:0]        rx_trigger
);
  sel_t                 sel;
  logic [DIV_BYTES-1:0] we_div;
  line_cfg_t            line_q;
  fifo_cfg_t            fifo_q;
  logic [IEN_W-1:0]     ien_q;
  logic [MDM_W-1:0]     mdm_q;
  logic                 latch;

  assign latch = line_q.latch;

  uart_regbank_decode #(.DIV_BYTES(DIV_BYTES)) u_dec (
    .addr   (reg_addr),
    .rd     (reg_rd),
    .wr     (reg_wr),
    .latch  (latch),
    .sel    (sel),
    .we_div (we_div)
  );

  uart_regbank_regs #(
    .DW(DW), .IEN_W(IEN_W), .MDM_W(MDM_W), .DIV_BYTES(DIV_BYTES)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .we_div  (we_div),
    .wdata   (reg_wdata),
    .line_q  (line_q),
    .fifo_q  (fifo_q),
    .ien_q   (ien_q),
    .mdm_q   (mdm_q),
    .div_q   (baud_div),
    .thr_q   (tx_byte),
    .push_q  (tx_push),
    .pop_q   (rx_pop),
    .rxclr_q (rx_fifo_clr),
    .txclr_q (tx_fifo_clr)
  );

  uart_regbank_rdmux #(
    .DW(DW), .IEN_W(IEN_W), .MDM_W(MDM_W), .DIV_BYTES(DIV_BYTES)
  ) u_rd (
    .addr       (reg_addr),
    .line_q     (line_q),
    .ien_q      (ien_q),
    .mdm_q      (mdm_q),
    .div_q      (baud_div),
    .rx_head    (rx_head),
    .irq_id     (irq_id),
    .line_stat  (line_stat),
    .modem_stat (modem_stat),
    .rdata      (reg_rdata)
  );

  assign int_en       = ien_q;
  assign word_len     = line_q.wlen;
  assign two_stop     = line_q.two_stop;
  assign parity_en    = line_q.par_en;
  assign parity_even  = line_q.even;
  assign parity_stick = line_q.stick;
  assign break_ctl    = line_q.brk;
  assign dtr          = mdm_q[0];
  assign rts          = mdm_q[1];
  assign out1         = mdm_q[2];
  assign out2         = mdm_q[3];
  assign loopback     = mdm_q[4];
  assign fifo_en      = fifo_q.enable;
  assign ready_mode   = fifo_q.rdy_mode;
  assign rx_trigger   = fifo_q.trig;
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  reg_addr,
  input logic        reg_rd,
  input logic        reg_wr,
  input logic [7:0]  reg_wdata,
  input logic        latch,
  input logic        tx_push,
  input logic        rx_pop,
  input logic        rx_fifo_clr,
  input logic        tx_fifo_clr,
  input logic [3:0]  int_en,
  input logic [15:0] baud_div,
  input logic [1:0]  word_len,
  input logic        dtr
);
  a_r2_push_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> $past(reg_wr && reg_addr == 3'd0 && !latch));

  a_r3_pop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> $past(reg_rd && reg_addr == 3'd0 && !latch));

  a_r4_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr && latch && reg_addr <= 3'd1) |-> $stable(baud_div));

  a_r5_ien_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr && !latch && reg_addr == 3'd1) |-> $stable(int_en));

  a_r7_rxclr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fifo_clr |-> $past(reg_wr && reg_addr == 3'd2 && reg_wdata[1]));

  a_r7_txclr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fifo_clr |-> $past(reg_wr && reg_addr == 3'd2 && reg_wdata[2]));

  a_r8_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr && reg_addr == 3'd3) |-> $stable(word_len));

  a_r9_modem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr && reg_addr == 3'd4) |-> $stable(dtr));
endmodule

bind uart_regbank uart_regbank_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_addr    (reg_addr),
  .reg_rd      (reg_rd),
  .reg_wr      (reg_wr),
  .reg_wdata   (reg_wdata),
  .latch       (latch),
  .tx_push     (tx_push),
  .rx_pop      (rx_pop),
  .rx_fifo_clr (rx_fifo_clr),
  .tx_fifo_clr (tx_fifo_clr),
  .int_en      (int_en),
  .baud_div    (baud_div),
  .word_len    (word_len),
  .dtr         (dtr)
);

// File: tb/tb_uart_regbank.sv
`timescale 1ns/1ps
module tb_uart_regbank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [2:0]  reg_addr = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0, reg_rdata;
  logic [7:0]  rx_head = 8'h00, irq_id = 8'h01, line_stat = 8'h60, modem_stat = 8'h00;
  logic [7:0]  tx_byte;
  logic        tx_push, rx_pop;
  logic [3:0]  int_en;
  logic [1:0]  word_len, rx_trigger;
  logic        two_stop, parity_en, parity_even, parity_stick, break_ctl;
  logic [15:0] baud_div;
  logic        dtr, rts, out1, out2, loopback;
  logic        fifo_en, rx_fifo_clr, tx_fifo_clr, ready_mode;

  uart_regbank dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_head(rx_head), .irq_id(irq_id),
    .line_stat(line_stat), .modem_stat(modem_stat), .tx_byte(tx_byte), .tx_push(tx_push),
    .rx_pop(rx_pop), .int_en(int_en), .word_len(word_len), .two_stop(two_stop),
    .parity_en(parity_en), .parity_even(parity_even), .parity_stick(parity_stick),
    .break_ctl(break_ctl), .baud_div(baud_div), .dtr(dtr), .rts(rts), .out1(out1),
    .out2(out2), .loopback(loopback), .fifo_en(fifo_en), .rx_fifo_clr(rx_fifo_clr),
    .tx_fifo_clr(tx_fifo_clr), .ready_mode(ready_mode), .rx_trigger(rx_trigger)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit running = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [7:0] m_line, m_ien, m_mdm, m_fifo, m_lo, m_hi, m_thr;
  logic       m_push, m_pop, m_rxclr, m_txclr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_line <= 0; m_ien <= 0; m_mdm <= 0; m_fifo <= 0; m_lo <= 0; m_hi <= 0; m_thr <= 0;
      m_push <= 0; m_pop <= 0; m_rxclr <= 0; m_txclr <= 0;
    end else begin
      m_push <= 0; m_pop <= 0; m_rxclr <= 0; m_txclr <= 0;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: if (m_line[7]) m_lo <= reg_wdata; else begin m_thr <= reg_wdata; m_push <= 1; end
          3'd1: if (m_line[7]) m_hi <= reg_wdata; else m_ien <= reg_wdata & 8'h0F;
          3'd2: begin m_fifo <= reg_wdata & 8'hC9; m_rxclr <= reg_wdata[1]; m_txclr <= reg_wdata[2]; end
          3'd3: m_line <= reg_wdata;
          3'd4: m_mdm <= reg_wdata & 8'h1F;
          default: ;
        endcase
      end
      if (reg_rd && reg_addr == 3'd0 && !m_line[7]) m_pop <= 1;
    end
  end

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_line[7] ? m_lo : rx_head;
      3'd1: return m_line[7] ? m_hi : m_ien;
      3'd2: return irq_id;
      3'd3: return m_line;
      3'd4: return m_mdm;
      3'd5: return line_stat;
      3'd6: return modem_stat;
      default: return 8'h00;
    endcase
  endfunction

  // Cycle-by-cycle comparison of all registered outputs
  always @(negedge clk) begin
    if (rst_n && running) begin
      check(tx_byte == m_thr, "R2 tx_byte", tx_byte, m_thr);
      check(tx_push == m_push, "R2 tx_push", tx_push, m_push);
      check(rx_pop == m_pop, "R3 rx_pop", rx_pop, m_pop);
      check(baud_div == {m_hi, m_lo}, "R4 baud_div", baud_div, {m_hi, m_lo});
      check(int_en == m_ien[3:0], "R5 int_en", int_en, m_ien[3:0]);
      check({rx_trigger, ready_mode, fifo_en} == {m_fifo[7:6], m_fifo[3], m_fifo[0]},
            "R6 fifo fields", {rx_trigger, ready_mode, fifo_en}, {m_fifo[7:6], m_fifo[3], m_fifo[0]});
      check({rx_fifo_clr, tx_fifo_clr} == {m_rxclr, m_txclr}, "R7 clear pulses",
            {rx_fifo_clr, tx_fifo_clr}, {m_rxclr, m_txclr});
      check({break_ctl, parity_stick, parity_even, parity_en, two_stop, word_len} == m_line[6:0],
            "R8 line fields", {break_ctl, parity_stick, parity_even, parity_en, two_stop, word_len}, m_line[6:0]);
      check({loopback, out2, out1, rts, dtr} == m_mdm[4:0], "R9 modem pins",
            {loopback, out2, out1, rts, dtr}, m_mdm[4:0]);
    end
  end

  task automatic access(input bit rd, input bit wr, input logic [2:0] a, input logic [7:0] d,
                        input string req);
    @(negedge clk);
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = d;
    #1;
    if (rd) check(reg_rdata == exp_read(a), req, reg_rdata, exp_read(a));
  endtask

  task automatic idle();
    @(negedge clk);
    reg_rd = 0; reg_wr = 0;
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check({tx_push, rx_pop, rx_fifo_clr, tx_fifo_clr} == 0, "R1 strobes idle", {tx_push, rx_pop, rx_fifo_clr, tx_fifo_clr}, 0);
    check(baud_div == 0 && int_en == 0 && word_len == 0, "R1 config zero", {baud_div, int_en, word_len}, 0);
    check({fifo_en, dtr, rts, out1, out2, loopback, break_ctl} == 0, "R1 pins low", {fifo_en, dtr, rts, out1, out2, loopback, break_ctl}, 0);
    rst_n = 1'b1;
    running = 1'b1;
    idle();

    // R4 divisor banking
    access(0, 1, 3'd3, 8'h83, "R8 line write");
    access(0, 1, 3'd0, 8'h34, "R4 low write");
    access(0, 1, 3'd1, 8'h12, "R4 high write");
    access(1, 0, 3'd0, 8'h00, "R4 low read");
    access(1, 0, 3'd1, 8'h00, "R4 high read");
    idle();
    check(baud_div == 16'h1234, "R4 divisor value", baud_div, 16'h1234);
    check(rx_pop == 0, "R4 no pop while latched", rx_pop, 0);
    access(1, 0, 3'd3, 8'h00, "R8 line read 0x83");

    // R2 data writes back to back
    access(0, 1, 3'd3, 8'h03, "R8 line write");
    access(0, 1, 3'd0, 8'h55, "R2 data write");
    access(0, 1, 3'd0, 8'hAA, "R2 data write 2");
    idle();
    check(tx_byte == 8'hAA && tx_push == 1, "R2 second byte", {tx_push, tx_byte}, 9'h1AA);
    idle();
    check(tx_push == 0, "R2 push drops", tx_push, 0);

    // R3 data reads
    rx_head = 8'h5A;
    access(1, 0, 3'd0, 8'h00, "R3 data read");
    idle();
    check(rx_pop == 1, "R3 pop pulse", rx_pop, 1);
    idle();
    check(rx_pop == 0, "R3 pop one cycle", rx_pop, 0);

    // R5 interrupt enable
    access(0, 1, 3'd1, 8'hFF, "R5 ien write");
    access(1, 0, 3'd1, 8'h00, "R5 ien read");
    idle();
    check(int_en == 4'hF && baud_div == 16'h1234, "R5 ien only", {int_en, baud_div}, {4'hF, 16'h1234});

    // R6/R7 offset 2
    irq_id = 8'hC4;
    access(1, 0, 3'd2, 8'h00, "R6 id read");
    access(0, 1, 3'd2, 8'hCF, "R7 fifo write");
    idle();
    check({rx_fifo_clr, tx_fifo_clr, fifo_en, ready_mode, rx_trigger} == 6'b111111, "R7 pulses and R6 fields",
          {rx_fifo_clr, tx_fifo_clr, fifo_en, ready_mode, rx_trigger}, 6'b111111);
    idle();
    check({rx_fifo_clr, tx_fifo_clr} == 0, "R7 pulses drop", {rx_fifo_clr, tx_fifo_clr}, 0);
    access(0, 1, 3'd2, 8'h41, "R6 fifo write 2");
    access(1, 0, 3'd2, 8'h00, "R6 id read not fifo");

    // R8/R9
    access(0, 1, 3'd3, 8'h7E, "R8 line write");
    access(1, 0, 3'd3, 8'h00, "R8 line read");
    access(0, 1, 3'd4, 8'hFF, "R9 modem write");
    access(1, 0, 3'd4, 8'h00, "R9 modem read");
    access(0, 1, 3'd4, 8'h0A, "R9 modem write 2");

    // R10/R11
    line_stat = 8'h61; modem_stat = 8'hB3;
    access(1, 0, 3'd5, 8'h00, "R10 line status read");
    access(1, 0, 3'd6, 8'h00, "R10 modem status read");
    access(0, 1, 3'd5, 8'hFF, "R11 write lstat");
    access(0, 1, 3'd6, 8'hFF, "R11 write mstat");
    access(0, 1, 3'd7, 8'hFF, "R11 write spare");
    access(1, 0, 3'd7, 8'h00, "R11 spare read");
    idle();
    check({int_en, baud_div, tx_push} == {4'hF, 16'h1234, 1'b0}, "R11 writes ignored",
          {int_en, baud_div, tx_push}, {4'hF, 16'h1234, 1'b0});

    // Random traffic, latch toggled often
    for (int i = 0; i < 400; i++) begin
      logic [2:0] a;
      logic [7:0] d;
      a = 3'($urandom_range(0, 7));
      d = 8'($urandom);
      if (a == 3'd3) d[7] = d[0];
      rx_head = 8'($urandom); irq_id = 8'($urandom);
      line_stat = 8'($urandom); modem_stat = 8'($urandom);
      access(1'($urandom), 1'($urandom), a, d, "R3 R4 random read");
    end
    idle();
    idle();
    report();
  end
endmodule